// File: doc/BRIEF.md
# Power-Fail Save and Power-Return Restore Sequencer

This block is the synchronous controller behind a shadow memory whose contents are mirrored in nonvolatile storage. It watches two supply comparator flags: one that trips when the supply falls under the switch-over threshold, and a deeper one that trips when the supply falls under the reset threshold. Both flags are resynchronised inside the block. From them it decides when to ask a transfer engine to copy the array into nonvolatile storage and when to copy it back.

On a supply drop, the active-low busy line is held low for a fixed window. If the array is clean, the busy line is then released. If the array is dirty, a save pulse is issued and the busy line stays low until the engine reports completion. A deep drop is remembered. When the supply next rises above the switch-over threshold, a restore pulse is issued. A shallow drop does not cause a restore.

Array writes pass through the block as a grant. They are refused while the supply is low and while a transfer is in flight. A save request from outside is honoured only on a healthy supply with a dirty array. Reset behaves like a fresh power-up: a restore is already pending.

Top module: `nvPowerSequencer`

## Requirements
- R1: After reset, the block behaves as at power-up. It issues no restore and grants no write while the low-supply flag is set. Once that flag clears, it issues exactly one restore pulse.
- R2: A supply drop on a clean array holds busyN low for exactly PULSE_CYCLES cycles, issues no save pulse, and then releases busyN.
- R3: A supply drop on a dirty array issues one save pulse when the PULSE_CYCLES window ends. busyN stays low until the cycle in which xferDone is seen, so the low time is PULSE_CYCLES plus the transfer time.
- R4: wrGrant follows wrReq only when the sequencer is idle, the low-supply flag is clear, and memDisable is low. Otherwise wrGrant is 0.
- R5: An external save request on a healthy supply starts a save only if the array is dirty. On a clean array it has no effect: no save pulse, and busyN stays high.
- R6: A deep-drop flag latches a restore request. The restore pulse is issued only after the low-supply flag has cleared.
- R7: A drop that trips only the low-supply flag never causes a restore when the supply returns.
- R8: memDisable is high from the cycle of a save or restore pulse up to and including the cycle in which xferDone is seen.
- R9: A granted write makes the array dirty. A completed save or restore makes it clean.
- R10: storeStart and recallStart are one-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset (power-up state) |
| supplyLowAsync | input | 1 | Comparator flag: supply under switch-over level (asynchronous) |
| supplyDeadAsync | input | 1 | Comparator flag: supply under reset level (asynchronous) |
| wrReq | input | 1 | Array write request from the access port |
| extStoreReq | input | 1 | External save request |
| xferDone | input | 1 | One-cycle completion from the transfer engine |
| wrGrant | output | 1 | Write allowed this cycle |
| busyN | output | 1 | Active-low busy / save-in-progress line |
| memDisable | output | 1 | Array access disabled during a transfer |
| storeStart | output | 1 | One-cycle save request to the engine |
| recallStart | output | 1 | One-cycle restore request to the engine |

## Verification
Some rules are checked by assertions on every cycle. These are: the start pulses are exclusive and one cycle long, a grant never coincides with a low supply or a disabled array, a save pulse comes with busy low and the array disabled, memDisable holds until done, a granted write leaves the array dirty, and a restore is never launched while the supply is low. Other behaviours can only be shown by the directed scenarios, because they depend on history over many cycles. These are: the exact busy-low window length, the choice between save and no save on a drop, the difference between a shallow and a deep drop on supply return, the power-up restore, and the effect of a completed transfer on the next drop.

// File: rtl/nvSeqPkg.sv
package nvSeqPkg;

  typedef enum logic [2:0] {
    ST_LOWWAIT = 3'd0,
    ST_IDLE    = 3'd1,
    ST_SENSE   = 3'd2,
    ST_STORE   = 3'd3,
    ST_RECALL  = 3'd4
  } seqState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic loadWin;
    logic stepWin;
    logic clrDirty;
    logic clrRecall;
  } seqStrobe_t;

  // datapath -> control status
  typedef struct packed {
    logic winDone;
    logic dirty;
    logic recallPend;
  } seqStatus_t;

endpackage

// File: rtl/nvSeqSync.sv
module nvSeqSync #(
  parameter int N_FLAGS = 2,
  parameter int STAGES  = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [N_FLAGS-1:0] asyncIn,
  output logic [N_FLAGS-1:0] syncOut
);

  for (genvar f = 0; f < N_FLAGS; f++) begin : gFlag
    logic [STAGES-1:0] chain;
    // Reset to 1: supply is assumed absent until the comparators say otherwise.
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= '1;
      else       chain <= {chain[STAGES-2:0], asyncIn[f]};
    end
    assign syncOut[f] = chain[STAGES-1];
  end

endmodule

// File: rtl/nvSeqData.sv
module nvSeqData
  import nvSeqPkg::*;
#(
  parameter int PULSE_CYCLES = 250
) (
  input  logic       clk,
  input  logic       rstN,
  input  seqStrobe_t strobe,
  input  logic       wrGrant,
  input  logic       deadS,
  output seqStatus_t status
);

  localparam int CW = $clog2(PULSE_CYCLES + 1);
  localparam logic [CW-1:0] WIN_LOAD = CW'(PULSE_CYCLES - 1);

  logic [CW-1:0] winCnt;
  logic          dirtyQ;
  logic          recallQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                           winCnt <= '0;
    else if (strobe.loadWin)             winCnt <= WIN_LOAD;
    else if (strobe.stepWin && winCnt != '0) winCnt <= winCnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               dirtyQ <= 1'b0;
    else if (strobe.clrDirty) dirtyQ <= 1'b0;
    else if (wrGrant)         dirtyQ <= 1'b1;
  end

  // Deep drop wins over a clear in the same cycle.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 recallQ <= 1'b1;
    else if (deadS)            recallQ <= 1'b1;
    else if (strobe.clrRecall) recallQ <= 1'b0;
  end

  assign status.winDone    = (winCnt == '0);
  assign status.dirty      = dirtyQ;
  assign status.recallPend = recallQ;

  // R9
  dirty_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrGrant |=> status.dirty);

  // R6
  recall_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
    deadS |=> status.recallPend);

endmodule

// File: rtl/nvSeqCtrl.sv
module nvSeqCtrl
  import nvSeqPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       lowS,
  input  seqStatus_t status,
  input  logic       wrReq,
  input  logic       extStoreReq,
  input  logic       xferDone,
  output seqStrobe_t strobe,
  output logic       wrGrant,
  output logic       busyN,
  output logic       memDisable,
  output logic       storeStart,
  output logic       recallStart
);

  seqState_t state, stateNext;
  logic      launchStore, launchRecall;

  always_comb begin
    stateNext    = state;
    strobe       = '0;
    launchStore  = 1'b0;
    launchRecall = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (lowS) begin
          stateNext      = ST_SENSE;
          strobe.loadWin = 1'b1;
        end else if (extStoreReq && status.dirty) begin
          stateNext   = ST_STORE;
          launchStore = 1'b1;
        end
      end
      ST_SENSE: begin
        strobe.stepWin = 1'b1;
        if (status.winDone) begin
          if (status.dirty) begin
            stateNext   = ST_STORE;
            launchStore = 1'b1;
          end else begin
            stateNext = ST_LOWWAIT;
          end
        end
      end
      ST_STORE: begin
        if (xferDone) begin
          strobe.clrDirty = 1'b1;
          stateNext       = lowS ? ST_LOWWAIT : ST_IDLE;
        end
      end
      ST_LOWWAIT: begin
        if (!lowS) begin
          if (status.recallPend) begin
            stateNext    = ST_RECALL;
            launchRecall = 1'b1;
          end else begin
            stateNext = ST_IDLE;
          end
        end
      end
      ST_RECALL: begin
        if (xferDone) begin
          strobe.clrDirty  = 1'b1;
          strobe.clrRecall = 1'b1;
          stateNext        = ST_IDLE;
        end
      end
      default: stateNext = ST_LOWWAIT;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_LOWWAIT;
      storeStart  <= 1'b0;
      recallStart <= 1'b0;
    end else begin
      state       <= stateNext;
      storeStart  <= launchStore;
      recallStart <= launchRecall;
    end
  end

  assign busyN      = !(state == ST_SENSE || state == ST_STORE);
  assign memDisable = (state == ST_STORE) || (state == ST_RECALL);
  assign wrGrant    = wrReq && (state == ST_IDLE) && !lowS;

  // R10
  start_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(storeStart && recallStart));

  // R10
  store_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    storeStart |=> !storeStart);

  // R10
  recall_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    recallStart |=> !recallStart);

  // R3
  store_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    storeStart |-> (!busyN && memDisable));

  // R8
  disable_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memDisable && !xferDone) |=> memDisable);

  // R8
  recall_disable_chk: assert property (@(posedge clk) disable iff (!rstN)
    recallStart |-> memDisable);

  // R4
  grant_safe_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrGrant |-> (!lowS && !memDisable && wrReq));

  // R6
  recall_supply_chk: assert property (@(posedge clk) disable iff (!rstN)
    recallStart |-> !lowS);

endmodule

// File: rtl/nvPowerSequencer.sv
module nvPowerSequencer
  import nvSeqPkg::*;
#(
  parameter int PULSE_CYCLES = 250,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic supplyLowAsync,
  input  logic supplyDeadAsync,
  input  logic wrReq,
  input  logic extStoreReq,
  input  logic xferDone,
  output logic wrGrant,
  output logic busyN,
  output logic memDisable,
  output logic storeStart,
  output logic recallStart
);

  logic [1:0] flagSync;
  seqStrobe_t strobe;
  seqStatus_t status;

  nvSeqSync #(.N_FLAGS(2), .STAGES(SYNC_STAGES)) uSync (
    .clk    (clk),
    .rstN   (rstN),
    .asyncIn({supplyDeadAsync, supplyLowAsync}),
    .syncOut(flagSync)
  );

  nvSeqCtrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .lowS       (flagSync[0]),
    .status     (status),
    .wrReq      (wrReq),
    .extStoreReq(extStoreReq),
    .xferDone   (xferDone),
    .strobe     (strobe),
    .wrGrant    (wrGrant),
    .busyN      (busyN),
    .memDisable (memDisable),
    .storeStart (storeStart),
    .recallStart(recallStart)
  );

  nvSeqData #(.PULSE_CYCLES(PULSE_CYCLES)) uData (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .wrGrant(wrGrant),
    .deadS  (flagSync[1]),
    .status (status)
  );

endmodule

// File: tb/nvPowerSequencer_test.sv
`timescale 1ns/1ps
module nvPowerSequencer_test;

  localparam int PULSE = 250;
  localparam int XFER  = 40;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lowA = 1'b1, deadA = 1'b1, wrReq = 1'b0, extReq = 1'b0, xferDone = 1'b0;
  logic wrGrant, busyN, memDisable, storeStart, recallStart;

  int checks = 0, errors = 0;
  int storeCnt = 0, recallCnt = 0;
  int busyRun = 0, lastBusyLen = 0, disRun = 0, lastDisLen = 0;
  int pulseRun = 0, maxPulse = 0, bothHigh = 0;
  int eng = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  nvPowerSequencer #(.PULSE_CYCLES(PULSE)) uut (
    .clk(clk), .rstN(rstN), .supplyLowAsync(lowA), .supplyDeadAsync(deadA),
    .wrReq(wrReq), .extStoreReq(extReq), .xferDone(xferDone),
    .wrGrant(wrGrant), .busyN(busyN), .memDisable(memDisable),
    .storeStart(storeStart), .recallStart(recallStart)
  );

  // transfer engine model: done one cycle after XFER cycles
  always @(negedge clk) begin
    xferDone <= 1'b0;
    if (storeStart || recallStart) eng <= XFER;
    else if (eng != 0) begin
      eng <= eng - 1;
      if (eng == 1) xferDone <= 1'b1;
    end
  end

  // observers
  always @(negedge clk) if (rstN) begin
    if (!busyN) busyRun++;
    else if (busyRun != 0) begin lastBusyLen = busyRun; busyRun = 0; end
    if (memDisable) disRun++;
    else if (disRun != 0) begin lastDisLen = disRun; disRun = 0; end
    if (storeStart) storeCnt++;
    if (recallStart) recallCnt++;
    if (storeStart || recallStart) begin
      pulseRun++;
      if (pulseRun > maxPulse) maxPulse = pulseRun;
    end else pulseRun = 0;
    if (storeStart && recallStart) bothHigh++;
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tryWrite(output int granted);
    wrReq = 1'b1;
    #0.5;
    granted = int'(wrGrant);
    cyc(1);
    wrReq = 1'b0;
  endtask

  task automatic testReset();
    int g;
    rstN = 1'b0; lowA = 1'b1; deadA = 1'b1;
    cyc(5);
    rstN = 1'b1;
    cyc(2);
    chk("R1 busyN after reset", int'(busyN), 1);
    chk("R1 memDisable after reset", int'(memDisable), 0);
    tryWrite(g);
    chk("R4 write refused at power-up", g, 0);
    cyc(20);
    chk("R1 no restore while low", recallCnt, 0);
    deadA = 1'b0; lowA = 1'b0;
    cyc(XFER + 20);
    chk("R1 one restore at power-up", recallCnt, 1);
    chk("R8 restore disable length", lastDisLen, XFER + 1);
    chk("R1 no save at power-up", storeCnt, 0);
  endtask

  task automatic testShallowClean();
    int g, s0, r0;
    s0 = storeCnt; r0 = recallCnt;
    lowA = 1'b1;
    cyc(6);
    chk("R2 busy low during window", int'(busyN), 0);
    tryWrite(g);
    chk("R4 write refused while low", g, 0);
    cyc(PULSE + 20);
    chk("R2 busy released", int'(busyN), 1);
    chk("R2 window length", lastBusyLen, PULSE);
    chk("R2 no save when clean", storeCnt, s0);
    lowA = 1'b0;
    cyc(XFER + 20);
    chk("R7 no restore after shallow drop", recallCnt, r0);
    tryWrite(g);
    chk("R4 write granted when healthy", g, 1);
  endtask

  task automatic testShallowDirty();
    int s0, r0;
    s0 = storeCnt; r0 = recallCnt;
    lowA = 1'b1;
    cyc(PULSE + XFER + 30);
    chk("R3 save launched when dirty", storeCnt, s0 + 1);
    chk("R3 busy low through save", lastBusyLen, PULSE + XFER + 1);
    chk("R8 save disable length", lastDisLen, XFER + 1);
    lowA = 1'b0;
    cyc(XFER + 20);
    chk("R7 no restore after dirty shallow drop", recallCnt, r0);
    // R9: save cleaned the array, so the next drop saves nothing
    lowA = 1'b1;
    cyc(PULSE + 20);
    chk("R9 clean after save", storeCnt, s0 + 1);
    lowA = 1'b0;
    cyc(10);
  endtask

  task automatic testExternal();
    int g, s0;
    s0 = storeCnt;
    extReq = 1'b1; cyc(1); extReq = 1'b0;
    cyc(20);
    chk("R5 external ignored when clean", storeCnt, s0);
    chk("R5 busy stays high", lastBusyLen, PULSE);
    tryWrite(g);
    chk("R9 write granted", g, 1);
    extReq = 1'b1; cyc(1); extReq = 1'b0;
    cyc(XFER + 20);
    chk("R5 external save when dirty", storeCnt, s0 + 1);
    chk("R5 busy low for save only", lastBusyLen, XFER + 1);
  endtask

  task automatic testDeep();
    int g, s0, r0;
    tryWrite(g);
    s0 = storeCnt; r0 = recallCnt;
    lowA = 1'b1; deadA = 1'b1;
    cyc(PULSE + XFER + 30);
    chk("R3 save on deep drop", storeCnt, s0 + 1);
    deadA = 1'b0;
    cyc(30);
    chk("R6 no restore while still low", recallCnt, r0);
    lowA = 1'b0;
    cyc(XFER + 20);
    chk("R6 restore after deep drop", recallCnt, r0 + 1);
    // deep drop on a clean array
    lowA = 1'b1; deadA = 1'b1;
    cyc(PULSE + 20);
    chk("R9 clean after restore", storeCnt, s0 + 1);
    deadA = 1'b0; lowA = 1'b0;
    cyc(XFER + 20);
    chk("R6 restore after clean deep drop", recallCnt, r0 + 2);
    chk("R10 pulse width", maxPulse, 1);
    chk("R10 never together", bothHigh, 0);
  endtask

  initial begin
    testReset();
    testShallowClean();
    testShallowDirty();
    testExternal();
    testDeep();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule